// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block brings a registered-style SDRAM module from power-up to a usable state. After reset it keeps every chip select deasserted and the clock enable low. When `start` is seen, it raises clock enable on all lines. It then issues a fixed, clock-counted series of one-cycle commands: a precharge of all banks, a train of auto-refreshes, and finally a write of the mode register. When that is complete it pulses `done` and parks the bus on NOP.

The command bus is seven bits wide. It is made of four chip-select lines followed by RAS, CAS and WE, all active low. The series is fixed in hardware. No memory model sits behind the block, and no delay is measured other than by counting clocks. A controller that follows this block takes over the bus once `done` has been seen.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and afterwards until `start` is sampled high, `cke` is all zeros, `cmd` is DESELECT (1111111), `addr` and `ba` are zero and `done` is low.
- R2: On the clock edge after the edge that samples `start` high, `cke` goes to all ones with DESELECT on `cmd` for one cycle. From then on `cke` never falls, and no code other than DESELECT appears while `cke` is low.
- R3: The next cycles carry NOP (1010111), then PRECHARGE (1010010) with `addr` bit 10 set, all other `addr` bits zero and `ba` zero, then two NOPs.
- R4: Sixteen groups of REFRESH (1010001), NOP, REFRESH, NOP follow, giving 32 refreshes, each followed directly by a NOP.
- R5: The last command is LOAD MODE (1010000) with `ba` zero and `addr` = 0x220. This value holds burst-length code 000 in bits [2:0], sequential type 0 in bit 3, CAS latency code 010 in bits [6:4], 00 in bits [8:7], single-location write burst 1 in bit 9 and zero above.
- R6: `done` is high for exactly one cycle, the cycle right after LOAD MODE, and NOP is on `cmd` during that cycle.
- R7: After `done`, the outputs hold NOP with `cke` all ones and `done` low until reset.
- R8: `start` has no effect while the series is running or after it has finished. Each reset allows one series only, even when `start` is held high throughout.
- R9: In every cycle whose command is NOP or DESELECT, `addr` and `ba` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the initialisation series (sampled while idle) |
| done | output | 1 | One-cycle pulse after the mode register write |
| cke | output | CKE_W (2) | Clock enable to every module rank |
| cmd | output | 7 | Chip selects [6:3], RAS, CAS, WE, active low |
| addr | output | ADDR_W (13) | Address bus |
| ba | output | BA_W (2) | Bank select |

## Verification
The bench compares every output on every cycle against a queue of expected bus states, built from the listed order. An off-by-one in the refresh count would therefore show up as a shifted or missing LOAD MODE. A design that raised `cke` in the same cycle as the first real command, or a cycle late, would fail the DESELECT-with-`cke` check. The bench pulses `start` in the middle of the refresh train and again after `done`, and in a second run holds it high throughout. A design that re-armed would show a second precharge, extra refreshes or a second `done` pulse. The mode word is checked bit for bit against 0x220, and the address and bank lines are checked to be zero on every idle cycle, which exposes stale row or mode bits left on the bus.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef logic [6:0] cmd_t;

  // {cs[3:0], ras, cas, we}, all active low
  localparam cmd_t CMD_DES = 7'b1111111;
  localparam cmd_t CMD_NOP = 7'b1010111;
  localparam cmd_t CMD_PRE = 7'b1010010;
  localparam cmd_t CMD_REF = 7'b1010001;
  localparam cmd_t CMD_LMR = 7'b1010000;

  // Steps ahead of the refresh train: cke-up, NOP, PRECHARGE, NOP, NOP
  localparam int PRE_STEPS = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN, PH_HOLD} phase_t;
endpackage

// File: rtl/sdram_init_mode.sv
module sdram_init_mode #(
  parameter int          ADDR_W    = 13,
  parameter logic [2:0]  BL_CODE   = 3'b000,
  parameter logic        BT_CODE   = 1'b0,
  parameter logic [2:0]  CL_CODE   = 3'b010,
  parameter logic [1:0]  OP_CODE   = 2'b00,
  parameter logic        WB_SINGLE = 1'b1
) (
  output logic [ADDR_W-1:0] mode_word
);
  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = BL_CODE;
    mode_word[3]   = BT_CODE;
    mode_word[6:4] = CL_CODE;
    mode_word[8:7] = OP_CODE;
    mode_word[9]   = WB_SINGLE;
  end
endmodule

// File: rtl/sdram_init_step.sv
module sdram_init_step
  import sdram_init_pkg::*;
#(
  parameter int REF_ITERS = 16,
  localparam int LAST     = PRE_STEPS + 4 * REF_ITERS,
  localparam int STEP_W   = $clog2(LAST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output phase_t            phase,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST_S = STEP_W'(LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      step  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_RUN;
          step  <= '0;
        end
        PH_RUN: begin
          if (step == LAST_S) phase <= PH_FIN;
          else                step  <= step + 1'b1;
        end
        PH_FIN:  phase <= PH_HOLD;
        default: phase <= PH_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/sdram_init_decode.sv
module sdram_init_decode
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int CKE_W     = 2,
  parameter int AP_BIT    = 10,
  parameter int REF_ITERS = 16,
  localparam int LAST     = PRE_STEPS + 4 * REF_ITERS,
  localparam int STEP_W   = $clog2(LAST + 1)
) (
  input  phase_t            phase,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] mode_word,
  output cmd_t              cmd_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [BA_W-1:0]   ba_d,
  output logic [CKE_W-1:0]  cke_d,
  output logic              done_d
);
  localparam logic [STEP_W-1:0] LAST_S = STEP_W'(LAST);
  localparam logic [STEP_W-1:0] REF_LO = STEP_W'(PRE_STEPS);

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = '0;
    cke_d  = (phase == PH_IDLE) ? '0 : '1;
    done_d = (phase == PH_FIN);
    case (phase)
      PH_IDLE: cmd_d = CMD_DES;
      PH_RUN: begin
        if (step == '0) begin
          cmd_d = CMD_DES;
        end else if (step == STEP_W'(2)) begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
        end else if (step == LAST_S) begin
          cmd_d  = CMD_LMR;
          addr_d = mode_word;
        end else if (step >= REF_LO && step[0] == REF_LO[0]) begin
          cmd_d = CMD_REF;
        end
      end
      default: cmd_d = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CKE_W     = 2,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter int REF_ITERS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic [CKE_W-1:0]  cke,
  output logic [6:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam int LAST   = PRE_STEPS + 4 * REF_ITERS;
  localparam int STEP_W = $clog2(LAST + 1);

  phase_t              phase;
  logic [STEP_W-1:0]   step;
  logic [ADDR_W-1:0]   mode_word;
  cmd_t                cmd_d;
  logic [ADDR_W-1:0]   addr_d;
  logic [BA_W-1:0]     ba_d;
  logic [CKE_W-1:0]    cke_d;
  logic                done_d;

  sdram_init_step #(.REF_ITERS(REF_ITERS)) u_step (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .step(step)
  );

  sdram_init_mode #(.ADDR_W(ADDR_W)) u_mode (.mode_word(mode_word));

  sdram_init_decode #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CKE_W(CKE_W),
    .AP_BIT(AP_BIT), .REF_ITERS(REF_ITERS)
  ) u_dec (
    .phase(phase), .step(step), .mode_word(mode_word),
    .cmd_d(cmd_d), .addr_d(addr_d), .ba_d(ba_d),
    .cke_d(cke_d), .done_d(done_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= CMD_DES;
      addr <= '0;
      ba   <= '0;
      cke  <= '0;
      done <= 1'b0;
    end else begin
      cmd  <= cmd_d;
      addr <= addr_d;
      ba   <= ba_d;
      cke  <= cke_d;
      done <= done_d;
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int CKE_W  = 2,
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [CKE_W-1:0]  cke,
  input logic [6:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba
);
  localparam logic [ADDR_W-1:0] EXP_MODE = ADDR_W'(12'h220);

  p_cmd_needs_cke_r2: assert property (@(posedge clk) disable iff (rst)
    (cke != '1) |-> (cmd == CMD_DES));
  p_cke_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (cke == '1) |=> (cke == '1));
  p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> (addr == (ADDR_W'(1) << AP_BIT) && ba == '0));
  p_ref_then_nop_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));
  p_mode_word_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LMR) |-> (addr == EXP_MODE && ba == '0));
  p_done_after_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LMR) |=> done);
  p_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cmd) == CMD_LMR && cmd == CMD_NOP));
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_hold_nop_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> (cmd == CMD_NOP && cke == '1));
  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NOP || cmd == CMD_DES) |-> (addr == '0 && ba == '0));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .CKE_W(CKE_W), .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)
) u_chk (.*);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int CKE_W = 2;
  localparam int ADDR_W = 13;
  localparam int BA_W = 2;
  localparam int REF_ITERS = 16;
  localparam int W = 1 + CKE_W + 7 + ADDR_W + BA_W;

  localparam logic [6:0] DES = 7'b1111111;
  localparam logic [6:0] NOP = 7'b1010111;
  localparam logic [6:0] PRE = 7'b1010010;
  localparam logic [6:0] REF = 7'b1010001;
  localparam logic [6:0] LMR = 7'b1010000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done;
  logic [CKE_W-1:0] cke;
  logic [6:0] cmd;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0] ba;

  sdram_init_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .cke(cke), .cmd(cmd), .addr(addr), .ba(ba)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit ready = 0;
  bit started = 0;
  int seen_ref, seen_lmr, seen_done, seen_pre;
  logic [W-1:0] q[$];
  logic [W-1:0] exp_v, hold_v;

  function automatic logic [W-1:0] mk(bit d, bit c, logic [6:0] cm, logic [ADDR_W-1:0] a);
    return {d, {CKE_W{c}}, cm, a, {BA_W{1'b0}}};
  endfunction

  function automatic void fill();
    q.push_back(mk(0, 1, DES, '0));
    q.push_back(mk(0, 1, NOP, '0));
    q.push_back(mk(0, 1, PRE, 13'h400));
    q.push_back(mk(0, 1, NOP, '0));
    q.push_back(mk(0, 1, NOP, '0));
    for (int i = 0; i < REF_ITERS; i++) begin
      q.push_back(mk(0, 1, REF, '0));
      q.push_back(mk(0, 1, NOP, '0));
      q.push_back(mk(0, 1, REF, '0));
      q.push_back(mk(0, 1, NOP, '0));
    end
    q.push_back(mk(0, 1, LMR, 13'h220));
    q.push_back(mk(1, 1, NOP, '0));
  endfunction

  // Reference model: expected bus state after each edge
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      started = 0;
      exp_v   = mk(0, 0, DES, '0);
      hold_v  = exp_v;
    end else begin
      if (q.size() > 0) exp_v = q.pop_front();
      else              exp_v = hold_v;
      if (start && !started) begin
        started = 1;
        fill();
        hold_v = mk(0, 1, NOP, '0);
      end
    end
    ready = 1;
  end

  task automatic check(string tag, bit ok, logic [W-1:0] got, logic [W-1:0] want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got done=%0b cke=%b cmd=%b addr=%h ba=%h, expected done=%0b cke=%b cmd=%b addr=%h ba=%h",
        tag, got[W-1], got[W-2 -: CKE_W], got[W-2-CKE_W -: 7], got[BA_W +: ADDR_W], got[BA_W-1:0],
        want[W-1], want[W-2 -: CKE_W], want[W-2-CKE_W -: 7], want[BA_W +: ADDR_W], want[BA_W-1:0]);
    end
  endtask

  task automatic check_cnt(string tag, int got, int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s: count got %0d expected %0d", tag, got, want);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      seen_ref = 0; seen_lmr = 0; seen_done = 0; seen_pre = 0;
    end
    if (ready && !finished) begin
      logic [W-1:0] got;
      logic [6:0] ecmd;
      string tag;
      got  = {done, cke, cmd, addr, ba};
      ecmd = exp_v[W-2-CKE_W -: 7];
      if (exp_v[W-1])                          tag = "R6";
      else if (ecmd == DES && !exp_v[W-2])     tag = "R1";
      else if (ecmd == DES)                    tag = "R2";
      else if (ecmd == PRE)                    tag = "R3";
      else if (ecmd == REF)                    tag = "R4";
      else if (ecmd == LMR)                    tag = "R5";
      else if (started && q.size() == 0)       tag = "R7";
      else                                     tag = "R3";
      check(tag, got[W-1:ADDR_W+BA_W] == exp_v[W-1:ADDR_W+BA_W], got, exp_v);
      check((ecmd == NOP || ecmd == DES) ? "R9" : tag,
            got[ADDR_W+BA_W-1:0] == exp_v[ADDR_W+BA_W-1:0], got, exp_v);
      if (cmd == REF) seen_ref++;
      if (cmd == LMR) seen_lmr++;
      if (cmd == PRE) seen_pre++;
      if (done) seen_done++;
    end
  end

  initial begin
    // Run 1: single start pulse, re-pulse mid-train and after completion (R8)
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (6) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    repeat (70) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    check_cnt("R4", seen_ref, 2 * REF_ITERS);
    check_cnt("R8", seen_pre, 1);
    check_cnt("R8", seen_lmr, 1);
    check_cnt("R6", seen_done, 1);
    // Run 2: start held high across the whole series (R8)
    rst = 1; repeat (2) @(negedge clk);
    rst = 0; start = 1;
    repeat (110) @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    check_cnt("R4", seen_ref, 2 * REF_ITERS);
    check_cnt("R8", seen_pre, 1);
    check_cnt("R8", seen_lmr, 1);
    check_cnt("R6", seen_done, 1);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R7: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule